// File: doc/BRIEF.md
# Two-Channel ADC Sampling Sequencer

This block sits between a register front end and an external multi-channel ADC. It controls the converter's power-down pin. After power-up it waits a programmable settling time, then steps a one-hot channel select through the channels in ascending order. It moves to the next channel only when the converter pulses data-valid. The result of each channel is held in a round buffer. The per-channel filter-match flags come from comparison logic outside the block and are valid together with data-valid. A round matches when any of its channels reported a match.

The block has three modes. Oneshot mode takes a single round, copies it into the sample registers, raises a done flag and halts. Normal mode repeats rounds back to back with the converter powered. Low-power mode sleeps between rounds and powers the converter for each round. In low-power mode the block counts consecutive matching rounds. When that count reaches a programmable target, it switches itself to continuous sampling, and a matching low-power round can raise a wakeup request. Three sticky status flags drive the interrupt and wakeup outputs. Software can clear them, and it can also force the sequencer and its counters back to idle at any time.

Top module: `adc_seq_ctrl`

## Requirements
- R1: At most one bit of `adc_sel_o` is ever high.
- R2: After enabling from idle, `adc_pd_o` falls first and `adc_sel_o` stays zero for exactly `pwrup_cnt_i`+1 cycles with power applied. A channel is selected only while `adc_pd_o` is low.
- R3: Channels are selected in ascending order starting at channel 0. A select is held unchanged until `adc_valid_i` is seen, and `adc_data_i` is captured on that cycle for the selected channel.
- R4: In oneshot mode (`mode_i`=0), one round is taken. Channel c lands in `sample_o[c*DW +: DW]` and status bit 0 is set. The converter is then powered down with no channel selected until `enable_i` is dropped.
- R5: In normal mode (`mode_i`=1), rounds repeat with `adc_pd_o` kept low. A round with any match sets status bit 1 and replaces all sample registers. A round with no match leaves the sample registers untouched.
- R6: In low-power mode (`mode_i`=2), each round is followed by `wake_cnt_i`+1 cycles powered down, then `pwrup_cnt_i`+1 settling cycles, then the next round.
- R7: In low-power mode, a round with no match resets the consecutive-match count to zero. The round that brings the count to `lp_target_i` starts continuous sampling at once, with no sleep.
- R8: A matching round in low-power sampling sets status bit 2, which drives `wake_o`, but only while `wake_en_i` is high. Normal mode never sets it.
- R9: Status bits are sticky until written 1 on `status_clr_i`. `intr_o` is the OR of status bits 0 and 1 masked by `intr_en_i` bits 0 and 1.
- R10: A pulse on `fsm_rst_i` returns the sequencer to idle on the next cycle, powered down with no select. It clears the settling, sleep and consecutive-match counters and the continuous-sampling state.
- R11: Out of reset, and on the cycle after `enable_i` falls, the converter is powered down with no select. Out of reset the status and sample registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Run the sequencer |
| mode_i | input | 2 | 0 oneshot, 1 normal, 2 low-power |
| pwrup_cnt_i | input | PWR_W | Settling cycles minus one |
| wake_cnt_i | input | WAKE_W | Sleep cycles between low-power rounds minus one |
| lp_target_i | input | LPC_W | Consecutive matching rounds before continuous sampling |
| fsm_rst_i | input | 1 | Software reset of sequencer and counters |
| intr_en_i | input | 2 | Interrupt masks for status bits 0 and 1 |
| wake_en_i | input | 1 | Allow low-power matches to request wakeup |
| status_clr_i | input | 3 | Write-1-to-clear for status bits |
| adc_data_i | input | DW | Converter result |
| adc_valid_i | input | 1 | Converter result valid pulse |
| match_i | input | NCH | Filter match per channel, valid with adc_valid_i |
| adc_pd_o | output | 1 | Converter power-down |
| adc_sel_o | output | NCH | One-hot channel select |
| sample_o | output | NCH*DW | Sample registers, channel c at c*DW |
| status_o | output | 3 | Sticky: 0 oneshot done, 1 match, 2 wakeup |
| intr_o | output | 1 | Interrupt |
| wake_o | output | 1 | Wakeup request |

## Verification
Oneshot rounds run with zero and non-zero settling counts and random converter latency. They show that the settling time is measured exactly and that a round halts. Normal-mode rounds use a mix of no-match, single-channel and dual-channel matches, which separates sample registers that update on every round from those that update only on matches. The low-power sequence 00, 01, 00, 11, 10 with a target of two promotes only on the last round, so a counter that fails to reset on a miss would be caught. Software resets issued during continuous sampling and mid-count show whether both the continuous-sampling state and the consecutive-match count are cleared.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PWRUP,
      ST_SAMP,
      ST_SLEEP,
      ST_HALT
   } seq_state_e;

   typedef enum logic [1:0] {
      MODE_ONESHOT = 2'd0,
      MODE_NORMAL  = 2'd1,
      MODE_LOWPWR  = 2'd2
   } seq_mode_e;

   localparam int unsigned NSTAT      = 3;
   localparam int unsigned STAT_DONE  = 0;
   localparam int unsigned STAT_MATCH = 1;
   localparam int unsigned STAT_WAKE  = 2;

endpackage

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
   parameter int unsigned W = 16
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         clr_i,
   input  logic         run_i,
   input  logic [W-1:0] limit_i,
   output logic         hit_o
);

   if (W < 1) begin : g_bad_w
      $error("adc_seq_timer: W must be at least 1");
   end

   logic [W-1:0] cnt_q;

   assign hit_o = (cnt_q == limit_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                cnt_q <= '0;
      else if (clr_i)             cnt_q <= '0;
      else if (run_i && !hit_o)   cnt_q <= cnt_q + W'(1);
   end

   // the interval count advances by one per running cycle (R2, R6)
   p_timer_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_i && !clr_i && !hit_o) |=> (cnt_q == $past(cnt_q) + W'(1)));

endmodule

// File: rtl/adc_seq_lpcount.sv
module adc_seq_lpcount #(
   parameter int unsigned W = 8
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         clr_i,
   input  logic         round_i,
   input  logic         hit_i,
   input  logic [W-1:0] target_i,
   output logic         promote_o
);

   if (W < 1) begin : g_bad_w
      $error("adc_seq_lpcount: W must be at least 1");
   end

   logic [W-1:0] cnt_q;
   logic         reach;

   assign reach     = (({1'b0, cnt_q} + (W+1)'(1)) == {1'b0, target_i});
   assign promote_o = round_i && hit_i && (target_i != '0) && reach;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              cnt_q <= '0;
      else if (clr_i)           cnt_q <= '0;
      else if (round_i) begin
         if (!hit_i || promote_o) cnt_q <= '0;
         else if (cnt_q != '1)    cnt_q <= cnt_q + W'(1);
      end
   end

   // a round without a match restarts the consecutive count (R7)
   p_miss_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (round_i && !hit_i) |=> (cnt_q == '0));

   // software reset empties the count (R10)
   p_clr_empties_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> (cnt_q == '0));

endmodule

// File: rtl/adc_seq_irq.sv
module adc_seq_irq #(
   parameter int unsigned NS = 3
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic [NS-1:0] set_i,
   input  logic [NS-1:0] clr_i,
   input  logic [NS-1:0] en_i,
   output logic [NS-1:0] status_o,
   output logic          intr_o
);

   if (NS < 1) begin : g_bad_ns
      $error("adc_seq_irq: NS must be at least 1");
   end

   logic [NS-1:0] stat_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stat_q <= '0;
      else         stat_q <= (stat_q & ~clr_i) | set_i;
   end

   assign status_o = stat_q;
   assign intr_o   = |(stat_q & en_i);

   for (genvar i = 0; i < NS; i++) begin : g_chk
      // a status bit stays set until cleared (R9)
      p_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (stat_q[i] && !clr_i[i]) |=> stat_q[i]);
      // a status bit only rises from a set request (R9)
      p_set_source_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
         $rose(stat_q[i]) |-> $past(set_i[i]));
   end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
   import adc_seq_pkg::*;
#(
   parameter int unsigned DW     = 10,
   parameter int unsigned NCH    = 2,
   parameter int unsigned PWR_W  = 8,
   parameter int unsigned WAKE_W = 16,
   parameter int unsigned LPC_W  = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              enable_i,
   input  logic [1:0]        mode_i,
   input  logic [PWR_W-1:0]  pwrup_cnt_i,
   input  logic [WAKE_W-1:0] wake_cnt_i,
   input  logic [LPC_W-1:0]  lp_target_i,
   input  logic              fsm_rst_i,
   input  logic [1:0]        intr_en_i,
   input  logic              wake_en_i,
   input  logic [2:0]        status_clr_i,
   input  logic [DW-1:0]     adc_data_i,
   input  logic              adc_valid_i,
   input  logic [NCH-1:0]    match_i,
   output logic              adc_pd_o,
   output logic [NCH-1:0]    adc_sel_o,
   output logic [NCH*DW-1:0] sample_o,
   output logic [2:0]        status_o,
   output logic              intr_o,
   output logic              wake_o
);

   localparam int unsigned CW = (NCH > 1) ? $clog2(NCH) : 1;
   localparam int unsigned TW = (PWR_W > WAKE_W) ? PWR_W : WAKE_W;

   if (NCH < 2 || DW < 1 || PWR_W < 1 || WAKE_W < 1 || LPC_W < 1) begin : g_bad_cfg
      $error("adc_seq_ctrl: illegal parameter set");
   end

   seq_state_e     state_q, state_d;
   logic [CW-1:0]  ch_q, ch_d;
   logic           hit_q, fast_q;
   logic [DW-1:0]  rnd_q [NCH];
   logic [DW-1:0]  smp_q [NCH];

   logic accept, last, hit_now, is_one, lp_phase, promote, stop;
   logic tmr_hit, tmr_run, tmr_clr;
   logic [TW-1:0] tmr_limit;
   logic [NSTAT-1:0] stat_set;

   assign stop     = fsm_rst_i || !enable_i;
   assign accept   = (state_q == ST_SAMP) && adc_valid_i;
   assign last     = accept && (ch_q == CW'(NCH-1));
   assign hit_now  = hit_q || match_i[ch_q];
   assign is_one   = (mode_i == MODE_ONESHOT);
   assign lp_phase = (mode_i == MODE_LOWPWR) && !fast_q;

   // ---------------- sequencing ----------------
   always_comb begin
      state_d = state_q;
      ch_d    = ch_q;
      if (stop) begin
         state_d = ST_IDLE;
         ch_d    = '0;
      end else begin
         unique case (state_q)
            ST_IDLE:  state_d = ST_PWRUP;
            ST_PWRUP: if (tmr_hit) begin
                         state_d = ST_SAMP;
                         ch_d    = '0;
                      end
            ST_SAMP:  if (accept) begin
                         if (last) begin
                            ch_d = '0;
                            if (is_one)                   state_d = ST_HALT;
                            else if (lp_phase && !promote) state_d = ST_SLEEP;
                         end else begin
                            ch_d = ch_q + CW'(1);
                         end
                      end
            ST_SLEEP: if (tmr_hit) state_d = ST_PWRUP;
            ST_HALT:  state_d = ST_HALT;
            default:  state_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         ch_q    <= '0;
         hit_q   <= 1'b0;
         fast_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         ch_q    <= ch_d;
         if (stop)          hit_q <= 1'b0;
         else if (accept)   hit_q <= last ? 1'b0 : hit_now;
         if (stop)          fast_q <= 1'b0;
         else if (promote)  fast_q <= 1'b1;
      end
   end

   // ---------------- shared interval timer ----------------
   assign tmr_run   = (state_q == ST_PWRUP) || (state_q == ST_SLEEP);
   assign tmr_limit = (state_q == ST_SLEEP) ? TW'(wake_cnt_i) : TW'(pwrup_cnt_i);
   assign tmr_clr   = fsm_rst_i || (state_d != state_q);

   adc_seq_timer #(.W(TW)) u_timer (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (tmr_clr),
      .run_i   (tmr_run),
      .limit_i (tmr_limit),
      .hit_o   (tmr_hit)
   );

   // ---------------- low-power consecutive-match count ----------------
   adc_seq_lpcount #(.W(LPC_W)) u_lpcount (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clr_i     (stop),
      .round_i   (last && lp_phase),
      .hit_i     (hit_now),
      .target_i  (lp_target_i),
      .promote_o (promote)
   );

   // ---------------- per-channel capture ----------------
   for (genvar c = 0; c < NCH; c++) begin : g_ch
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            rnd_q[c] <= '0;
            smp_q[c] <= '0;
         end else begin
            if (accept && (ch_q == CW'(c))) rnd_q[c] <= adc_data_i;
            if (last && (is_one || hit_now))
               smp_q[c] <= (c == NCH-1) ? adc_data_i : rnd_q[c];
         end
      end
      assign adc_sel_o[c]          = (state_q == ST_SAMP) && (ch_q == CW'(c));
      assign sample_o[c*DW +: DW]  = smp_q[c];
   end

   assign adc_pd_o = !((state_q == ST_PWRUP) || (state_q == ST_SAMP));

   // ---------------- status, interrupt, wakeup ----------------
   always_comb begin
      stat_set             = '0;
      stat_set[STAT_DONE]  = last && is_one;
      stat_set[STAT_MATCH] = last && hit_now && !is_one;
      stat_set[STAT_WAKE]  = last && hit_now && lp_phase && wake_en_i;
   end

   adc_seq_irq #(.NS(NSTAT)) u_irq (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .set_i    (stat_set),
      .clr_i    (status_clr_i),
      .en_i     ({1'b0, intr_en_i}),
      .status_o (status_o),
      .intr_o   (intr_o)
   );

   assign wake_o = status_o[STAT_WAKE];

   // ---------------- assertions ----------------
   p_sel_onehot_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(adc_sel_o));

   p_sel_powered_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|adc_sel_o) |-> !adc_pd_o);

   p_settle_first_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(adc_pd_o) |-> (adc_sel_o == '0));

   p_order_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (accept && !last && !stop) |=> (adc_sel_o == ($past(adc_sel_o) << 1)));

   p_hold_sel_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((|adc_sel_o) && !adc_valid_i && !stop) |=> $stable(adc_sel_o));

   p_halt_after_oneshot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (last && is_one) |=> (adc_pd_o && adc_sel_o == '0));

   p_wake_source_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(wake_o) |-> ($past(mode_i) == MODE_LOWPWR && $past(wake_en_i)));

   p_fsm_reset_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fsm_rst_i |=> (adc_pd_o && adc_sel_o == '0));

   p_disable_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !enable_i |=> (adc_pd_o && adc_sel_o == '0));

endmodule

// File: tb/sim_adc_seq_ctrl.sv
`timescale 1ns/1ps
module sim_adc_seq_ctrl;

   localparam int DW = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        enable;
   logic [1:0]  mode;
   logic [7:0]  pwrup;
   logic [15:0] wakec;
   logic [7:0]  target;
   logic        fsm_rst;
   logic [1:0]  intr_en;
   logic        wake_en;
   logic [2:0]  stat_clr;
   logic [DW-1:0] adc_data;
   logic        adc_valid;
   logic [1:0]  match;
   logic        pd;
   logic [1:0]  sel;
   logic [2*DW-1:0] sample;
   logic [2:0]  status;
   logic        intr;
   logic        wake;

   int checks = 0;
   int errors = 0;
   logic [DW-1:0] cur_d [2];
   logic [DW-1:0] exp_s [2];

   always #2 clk = ~clk;

   adc_seq_ctrl u0 (
      .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .mode_i(mode),
      .pwrup_cnt_i(pwrup), .wake_cnt_i(wakec), .lp_target_i(target),
      .fsm_rst_i(fsm_rst), .intr_en_i(intr_en), .wake_en_i(wake_en),
      .status_clr_i(stat_clr), .adc_data_i(adc_data), .adc_valid_i(adc_valid),
      .match_i(match), .adc_pd_o(pd), .adc_sel_o(sel), .sample_o(sample),
      .status_o(status), .intr_o(intr), .wake_o(wake)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   function automatic logic [63:0] onehot(input int c);
      return 64'(1) << c;
   endfunction

   task automatic serve_ch(input int c, input logic m);
      int n = 0;
      while (sel == 2'b00 && n < 500) begin
         tick();
         n++;
      end
      chk("R3 channel order", 64'(sel), onehot(c));
      chk("R2 powered while selected", 64'(pd), 64'(0));
      repeat ($urandom_range(0, 3)) begin
         tick();
         chk("R3 select held until valid", 64'(sel), onehot(c));
      end
      cur_d[c]  = DW'($urandom_range(0, 1023));
      adc_data  = cur_d[c];
      adc_valid = 1'b1;
      match[c]  = m;
      tick();
      adc_valid = 1'b0;
      match     = 2'b00;
   endtask

   task automatic do_round(input logic [1:0] m);
      serve_ch(0, m[0]);
      serve_ch(1, m[1]);
   endtask

   task automatic measure_gap(output int hi, output int lo);
      hi = 0;
      lo = 0;
      while (pd && sel == 2'b00 && hi < 5000) begin hi++; tick(); end
      while (!pd && sel == 2'b00 && lo < 5000) begin lo++; tick(); end
   endtask

   function automatic logic [63:0] exp_sample();
      return 64'({exp_s[1], exp_s[0]});
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL R11 watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int hi, lo, p, w;
      logic [1:0] m;
      logic stat1;
      void'($urandom(32'd1234));
      rst_n = 1'b0; enable = 1'b0; mode = 2'd0; pwrup = '0; wakec = '0;
      target = '0; fsm_rst = 1'b0; intr_en = '0; wake_en = 1'b0;
      stat_clr = '0; adc_data = '0; adc_valid = 1'b0; match = '0;
      exp_s[0] = '0; exp_s[1] = '0;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();

      // reset state
      chk("R11 reset power-down", 64'(pd), 64'(1));
      chk("R11 reset select", 64'(sel), 64'(0));
      chk("R11 reset status", 64'(status), 64'(0));
      chk("R11 reset interrupt", 64'(intr), 64'(0));
      chk("R11 reset wake", 64'(wake), 64'(0));
      chk("R11 reset samples", 64'(sample), 64'(0));

      // oneshot, zero and random settling
      for (int it = 0; it < 3; it++) begin
         p = (it == 0) ? 0 : $urandom_range(1, 9);
         mode = 2'd0; pwrup = 8'(p); intr_en = 2'b01;
         enable = 1'b1;
         measure_gap(hi, lo);
         chk("R2 settling length", 64'(lo), 64'(p + 1));
         m = 2'($urandom_range(0, 3));
         do_round(m);
         exp_s = cur_d;
         chk("R4 oneshot samples", 64'(sample), exp_sample());
         chk("R4 oneshot done bit", 64'(status[0]), 64'(1));
         chk("R9 oneshot interrupt", 64'(intr), 64'(1));
         chk("R5 no match flag in oneshot", 64'(status[1]), 64'(0));
         repeat (3) tick();
         chk("R4 halted power-down", 64'(pd), 64'(1));
         chk("R4 halted select", 64'(sel), 64'(0));
         enable = 1'b0;
         tick();
         stat_clr = 3'b001;
         tick();
         stat_clr = 3'b000;
         chk("R9 clear status", 64'(status), 64'(0));
         chk("R9 interrupt follows clear", 64'(intr), 64'(0));
      end

      // normal mode
      p = $urandom_range(0, 6);
      mode = 2'd1; pwrup = 8'(p); intr_en = 2'b10; wake_en = 1'b1;
      enable = 1'b1;
      measure_gap(hi, lo);
      chk("R2 settling length normal", 64'(lo), 64'(p + 1));
      stat1 = 1'b0;
      for (int k = 0; k < 8; k++) begin
         m = (k == 0) ? 2'b00 : (k == 1) ? 2'b10 : (k == 2) ? 2'b00 : 2'($urandom_range(0, 3));
         do_round(m);
         if (m != 2'b00) exp_s = cur_d;
         stat1 = stat1 | (m != 2'b00);
         chk("R5 samples only on match", 64'(sample), exp_sample());
         chk("R5 stays powered", 64'(pd), 64'(0));
         chk("R5 match status", 64'(status[1]), 64'(stat1));
         chk("R8 no wake in normal mode", 64'(wake), 64'(0));
         chk("R9 interrupt masked OR", 64'(intr), 64'(stat1));
      end
      intr_en = 2'b00;
      #1;
      chk("R9 interrupt masked off", 64'(intr), 64'(0));
      chk("R9 status kept while masked", 64'(status[1]), 64'(1));
      enable = 1'b0;
      tick();
      chk("R11 disable powers down", 64'(pd), 64'(1));
      chk("R11 disable drops select", 64'(sel), 64'(0));
      stat_clr = 3'b111;
      tick();
      stat_clr = 3'b000;

      // low-power mode
      p = $urandom_range(0, 6);
      w = $urandom_range(0, 12);
      mode = 2'd2; pwrup = 8'(p); wakec = 16'(w); target = 8'd2;
      wake_en = 1'b0; intr_en = 2'b10;
      enable = 1'b1;
      measure_gap(hi, lo);
      chk("R2 settling length low-power", 64'(lo), 64'(p + 1));
      for (int k = 0; k < 4; k++) begin
         m = (k == 0) ? 2'b00 : (k == 1) ? 2'b01 : (k == 2) ? 2'b00 : 2'b11;
         do_round(m);
         chk("R7 no early promotion", 64'(pd), 64'(1));
         measure_gap(hi, lo);
         chk("R6 sleep length", 64'(hi), 64'(w + 1));
         chk("R6 re-settle length", 64'(lo), 64'(p + 1));
      end
      do_round(2'b10);
      chk("R7 promoted stays powered", 64'(pd), 64'(0));
      chk("R7 promoted next select", 64'(sel), 64'(1));
      chk("R8 wake needs enable", 64'(wake), 64'(0));
      do_round(2'b00);
      chk("R7 continuous after promotion", 64'(pd), 64'(0));

      // software reset while continuous
      wake_en = 1'b1;
      fsm_rst = 1'b1;
      tick();
      fsm_rst = 1'b0;
      chk("R10 reset to idle power-down", 64'(pd), 64'(1));
      chk("R10 reset to idle select", 64'(sel), 64'(0));
      measure_gap(hi, lo);
      chk("R10 settling restarts", 64'(lo), 64'(p + 1));
      do_round(2'b01);
      chk("R10 continuous state cleared", 64'(pd), 64'(1));
      chk("R8 wake raised", 64'(wake), 64'(1));
      chk("R8 wake status bit", 64'(status[2]), 64'(1));

      // software reset mid-count
      fsm_rst = 1'b1;
      tick();
      fsm_rst = 1'b0;
      measure_gap(hi, lo);
      do_round(2'b01);
      chk("R10 match count cleared", 64'(pd), 64'(1));
      measure_gap(hi, lo);
      chk("R6 sleep after reset", 64'(hi), 64'(w + 1));
      do_round(2'b10);
      chk("R7 promotion after two", 64'(pd), 64'(0));
      stat_clr = 3'b100;
      tick();
      stat_clr = 3'b000;
      chk("R9 wake cleared", 64'(wake), 64'(0));
      chk("R1 select one-hot", 64'($countones(sel) <= 1), 64'(1));

      enable = 1'b0;
      tick();
      chk("R11 final disable", 64'(pd), 64'(1));

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule